// File: doc/BRIEF.md
# Banked Host Register File with Presence Counter

This block is the byte-wide register front end of a network controller. A host reaches it through a plain address/data port with separate read and write strobes. Sixteen offsets are visible at a time, and three banks share them. Offset 0 is the control register and is reachable from every bank. A write to it either switches the active bank or issues a command opcode. Commands appear on a one-cycle strobe output for the rest of the chip to act on.

Bank 0 holds the following registers:
- Interrupt status, with pending flags that sticky event inputs set and that write-one-to-clear resets.
- The identification register, whose fixed low bits carry a signature and whose top two bits count host reads so that a probe can tell a live device from an open bus.
- The interrupt mask.

Bank 1 holds the receive-buffer lower and upper page limits. Bank 2 holds the six station-address bytes. Read data is combinational from the address and the current bank.

Top module: `nic_bank_regs`

## Requirements
- R1: After reset the active bank is 0, the ID register reads 0x24, the mask reads 0x0F, status reads 0, every limit and address byte reads 0, and both `cmd_valid` and `irq` are low.
- R2: A write to offset 0 with bits 7:6 equal to 00, 01 or 10 makes bank 0, 1 or 2 active. Offset 0 reads back the bank in bits 7:6 and zero below, in every bank.
- R3: A write to offset 0 with bits 7:6 equal to 11 changes neither the bank nor the command outputs.
- R4: In bank 0, offset 2 reads bits 5:0 as 0x24, so the value masked with 0x2C equals 0x24. Bits 7:6 carry the read counter.
- R5: The read counter advances by one, wrapping from 3 to 0, at each clock edge where a read strobe hits bank 0 offset 2. It does not advance while no read strobe is asserted, and reads of other offsets or banks do not advance it.
- R6: A write to offset 0 with bits 7:6 = 00 and a non-zero bits 4:0 raises `cmd_valid` for exactly the next cycle, with `cmd_op` equal to bits 4:0. An opcode of 0 gives no pulse, and bit 5 is ignored.
- R7: A high `evt[i]` sets status bit i (bank 0 offset 1, bits 3:0). A status write clears the bits written as 1, and a set in the same cycle wins over the clear. Writing 0x0F clears all flags.
- R8: The mask is at bank 0 offset 3 and is read/write in bits 3:0, with bits 7:4 reading 0. Its bits are receive-stop (bit 0), receive (bit 1), transmit (bit 2) and execution (bit 3). A mask bit of 1 blocks its flag. `irq` is high when some status bit is set and its mask bit is 0.
- R9: In bank 1, offsets 8 and 9 are full-byte read/write registers for the receive lower and upper limit pages.
- R10: In bank 2, offsets 4 to 9 are full-byte read/write registers for station-address bytes 0 to 5.
- R11: Every offset not listed above reads 0, and writes to it change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| evt | input | 4 | Interrupt event inputs, set status flags |
| rdata | output | 8 | Read data for `addr` in the active bank |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 5 | Command opcode, valid with `cmd_valid` |
| irq | output | 1 | Unmasked pending interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit data, 4-bit offsets, four interrupt flags and six address bytes. With these values all sixteen offsets in all three banks, and the illegal bank code, are reachable from random traffic. The two-bit counter wraps within a handful of probe reads, so the 3-to-0 wrap is exercised. Directed cases cover set-versus-clear collisions in status, opcode zero, and reads held without a strobe.

// File: rtl/nicregs_pkg.sv
package nicregs_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_CTRL, K_STAT, K_IDENT, K_MASK, K_RXLO, K_RXHI, K_STA
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [2:0] idx;
  } reg_sel_t;

  localparam logic [1:0] BANK_ILLEGAL = 2'b11;
  localparam logic [5:0] IDENT_SIG    = 6'h24;
  localparam int         STA_BASE     = 4;

  function automatic reg_sel_t decode(input logic [1:0] bank,
                                      input logic [7:0] off,
                                      input int         sta_n);
    reg_sel_t s;
    s.kind = K_NONE;
    s.idx  = '0;
    if (off == 8'd0) s.kind = K_CTRL;
    else begin
      case (bank)
        2'd0: case (off)
          8'd1: s.kind = K_STAT;
          8'd2: s.kind = K_IDENT;
          8'd3: s.kind = K_MASK;
          default: s.kind = K_NONE;
        endcase
        2'd1: case (off)
          8'd8: s.kind = K_RXLO;
          8'd9: s.kind = K_RXHI;
          default: s.kind = K_NONE;
        endcase
        2'd2: if (int'(off) >= STA_BASE && int'(off) < STA_BASE + sta_n) begin
          s.kind = K_STA;
          s.idx  = 3'(int'(off) - STA_BASE);
        end
        default: s.kind = K_NONE;
      endcase
    end
    return s;
  endfunction

  function automatic logic [1:0] cnt_step(input logic [1:0] c);
    return c + 2'd1;
  endfunction

  function automatic logic [7:0] ident_value(input logic [1:0] c);
    return {c, IDENT_SIG};
  endfunction
endpackage

// File: rtl/nicregs_decode.sv
module nicregs_decode
  import nicregs_pkg::*;
#(
  parameter int AW    = 4,
  parameter int STA_N = 6
) (
  input  logic [1:0]    bank,
  input  logic [AW-1:0] addr,
  output reg_sel_t      sel
);
  always_comb sel = decode(bank, 8'(addr), STA_N);
endmodule

// File: rtl/nicregs_idcnt.sv
module nicregs_idcnt
  import nicregs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_hit,
  output logic [1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (rd_hit) cnt <= cnt_step(cnt);
  end

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> cnt == 2'($past(cnt) + 2'd1));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(cnt));
endmodule

// File: rtl/nicregs_irq.sv
module nicregs_irq #(
  parameter int IRQW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IRQW-1:0] evt,
  input  logic            stat_wr,
  input  logic            mask_wr,
  input  logic [IRQW-1:0] wbits,
  output logic [IRQW-1:0] pend,
  output logic [IRQW-1:0] mask,
  output logic            irq
);
  logic [IRQW-1:0] clr;
  assign clr = stat_wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '1;
    end else begin
      pend <= (pend & ~clr) | evt;
      if (mask_wr) mask <= wbits;
    end
  end

  assign irq = |(pend & ~mask);

  a_r7_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0) |=> ((pend & ~$past(pend)) == '0));
endmodule

// File: rtl/nic_bank_regs.sv
module nic_bank_regs
  import nicregs_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int IRQW  = 4,
  parameter int STA_N = 6,
  parameter int OPW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [IRQW-1:0] evt,
  output logic [DW-1:0]   rdata,
  output logic            cmd_valid,
  output logic [OPW-1:0]  cmd_op,
  output logic            irq
);
  localparam int BANK_LSB = DW - 2;

  reg_sel_t        sel;
  logic [1:0]      bank_q;
  logic [1:0]      id_cnt;
  logic [IRQW-1:0] pend, mask;
  logic [DW-1:0]   rxlo_q, rxhi_q;
  logic [DW-1:0]   sta_q [STA_N];

  // named internal events
  logic [1:0] wr_bank_code;
  logic       ctrl_wr, bank_wr, cmd_hit, id_rd_hit;
  assign wr_bank_code = wdata[DW-1:BANK_LSB];
  assign ctrl_wr   = wr_en && (sel.kind == K_CTRL);
  assign bank_wr   = ctrl_wr && (wr_bank_code != BANK_ILLEGAL);
  assign cmd_hit   = ctrl_wr && (wr_bank_code == 2'b00) && (wdata[OPW-1:0] != '0);
  assign id_rd_hit = rd_en && (sel.kind == K_IDENT);

  nicregs_decode #(.AW(AW), .STA_N(STA_N)) u_dec (
    .bank(bank_q), .addr(addr), .sel(sel));

  nicregs_idcnt u_id (
    .clk(clk), .rst_n(rst_n), .rd_hit(id_rd_hit), .cnt(id_cnt));

  nicregs_irq #(.IRQW(IRQW)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .stat_wr(wr_en && sel.kind == K_STAT),
    .mask_wr(wr_en && sel.kind == K_MASK),
    .wbits(wdata[IRQW-1:0]),
    .pend(pend), .mask(mask), .irq(irq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q    <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      rxlo_q    <= '0;
      rxhi_q    <= '0;
    end else begin
      if (bank_wr) bank_q <= wr_bank_code;
      cmd_valid <= cmd_hit;
      if (cmd_hit) cmd_op <= wdata[OPW-1:0];
      if (wr_en && sel.kind == K_RXLO) rxlo_q <= wdata;
      if (wr_en && sel.kind == K_RXHI) rxhi_q <= wdata;
    end
  end

  for (genvar g = 0; g < STA_N; g++) begin : g_sta
    always_ff @(posedge clk) begin
      if (!rst_n) sta_q[g] <= '0;
      else if (wr_en && sel.kind == K_STA && int'(sel.idx) == g) sta_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel.kind)
      K_CTRL:  rdata[DW-1:BANK_LSB] = bank_q;
      K_STAT:  rdata[IRQW-1:0] = pend;
      K_IDENT: rdata = DW'(ident_value(id_cnt));
      K_MASK:  rdata[IRQW-1:0] = mask;
      K_RXLO:  rdata = rxlo_q;
      K_RXHI:  rdata = rxhi_q;
      K_STA:   rdata = sta_q[sel.idx];
      default: rdata = '0;
    endcase
  end

  a_r3_no_illegal_bank: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != BANK_ILLEGAL);
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == '0) |=> $stable(bank_q));
  a_r6_cmd_origin: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(wr_en && addr == '0 && wdata[DW-1:BANK_LSB] == 2'b00));
  a_r6_cmd_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_op != '0);
  a_r4_signature: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.kind == K_IDENT) |-> ((rdata & 8'h2C) == 8'h24));
endmodule

// File: tb/nic_bank_regs_tb.sv
module nic_bank_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0, evt = 0;
  logic [7:0] wdata = 0, rdata;
  logic       cmd_valid, irq;
  logic [4:0] cmd_op;

  int n_chk = 0, n_err = 0;
  bit cv_seen; logic [4:0] op_seen;

  // model
  logic [1:0] m_bank = 0, m_cnt = 0;
  logic [3:0] m_pend = 0, m_mask = 4'hF;
  logic [7:0] m_lo = 0, m_hi = 0;
  logic [7:0] m_sta [6] = '{default: 8'h00};

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_bank_regs dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .evt(evt), .rdata(rdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .irq(irq));

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    if (a == 0) return {m_bank, 6'h0};
    case (m_bank)
      2'd0: case (a) 1: return {4'h0, m_pend}; 2: return {m_cnt, 6'h24};
                      3: return {4'h0, m_mask}; default: return 8'h00; endcase
      2'd1: if (a == 8) return m_lo; else if (a == 9) return m_hi; else return 8'h00;
      2'd2: if (a >= 4 && a <= 9) return m_sta[a-4]; else return 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(m_pend & ~m_mask);
  endfunction

  task automatic wr(logic [3:0] a, logic [7:0] d);
    logic ecv;
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1; cv_seen = cmd_valid; op_seen = cmd_op;
    @(negedge clk); wr_en = 0;
    ecv = (a == 0) && (d[7:6] == 2'b00) && (d[4:0] != 0);
    chk("R6 cmd_valid", {7'h0, cv_seen}, {7'h0, ecv});
    if (ecv) chk("R6 cmd_op", {3'h0, op_seen}, {3'h0, d[4:0]});
    if (a == 0) begin if (d[7:6] != 2'b11) m_bank = d[7:6]; end
    else if (m_bank == 0 && a == 1) m_pend = m_pend & ~d[3:0];
    else if (m_bank == 0 && a == 3) m_mask = d[3:0];
    else if (m_bank == 1 && a == 8) m_lo = d;
    else if (m_bank == 1 && a == 9) m_hi = d;
    else if (m_bank == 2 && a >= 4 && a <= 9) m_sta[a-4] = d;
  endtask

  task automatic rd(logic [3:0] a, string tag);
    @(negedge clk); rd_en = 1; addr = a; #1;
    chk(tag, rdata, exp_rd(a));
    @(posedge clk); #1;
    if (m_bank == 0 && a == 2) m_cnt = m_cnt + 2'd1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic fire(logic [3:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = 0; m_pend = m_pend | v;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq", {7'h0, irq}, 8'h00);
    chk("R1 cmd_valid", {7'h0, cmd_valid}, 8'h00);
    addr = 2; #1; chk("R1 ident no strobe", rdata, 8'h24);
    addr = 3; #1; chk("R1 mask", rdata, 8'h0F);
    addr = 1; #1; chk("R1 status", rdata, 8'h00);
    // R5 holding address without strobe does not advance
    addr = 2; repeat (3) @(negedge clk); #1;
    chk("R5 held no strobe", rdata, 8'h24);
    // R4/R5 counter across wrap
    for (int i = 0; i < 5; i++) rd(2, "R4 R5 ident read");
    // R5 other offsets don't advance
    rd(1, "R5 other offset"); rd(2, "R5 after other");
    // R2 bank switching, R9 R10 R11
    wr(0, 8'h40); rd(0, "R2 bank1 readback");
    rd(2, "R5 R11 offset2 in bank1");
    wr(8, 8'h3C); wr(9, 8'hA5); rd(8, "R9 lower"); rd(9, "R9 upper");
    wr(5, 8'h77); rd(5, "R11 unmapped bank1");
    wr(0, 8'h80); rd(0, "R2 bank2 readback");
    for (int i = 4; i <= 9; i++) wr(4'(i), 8'(8'h10 * i + 1));
    for (int i = 4; i <= 9; i++) rd(4'(i), "R10 station byte");
    rd(10, "R11 bank2 offset10");
    // R3 illegal bank code
    wr(0, 8'hC7); rd(0, "R3 bank unchanged");
    // R6 commands and bit5, opcode 0
    wr(0, 8'h2B); rd(0, "R2 command selects bank0");
    wr(0, 8'h20);
    wr(0, 8'h0E);
    @(negedge clk); chk("R6 one cycle pulse", {7'h0, cmd_valid}, 8'h00);
    // R7 R8 status/mask/irq
    fire(4'b0101); rd(1, "R7 set");
    chk("R8 irq masked", {7'h0, irq}, {7'h0, exp_irq()});
    wr(3, 8'hFB); rd(3, "R8 mask upper bits zero");
    @(negedge clk); chk("R8 irq unmasked tx", {7'h0, irq}, {7'h0, exp_irq()});
    wr(1, 8'h04); rd(1, "R7 w1c");
    chk("R8 irq cleared", {7'h0, irq}, {7'h0, exp_irq()});
    // R7 set wins over clear same cycle
    @(negedge clk); wr_en = 1; addr = 1; wdata = 8'h0F; evt = 4'b0010;
    @(negedge clk); wr_en = 0; evt = 0; m_pend = 4'b0010;
    rd(1, "R7 set wins");
    wr(1, 8'h0F); rd(1, "R7 clear all");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a; logic [7:0] d; int unsigned k;
      k = $urandom % 10; a = 4'($urandom); d = 8'($urandom);
      if (k < 2) wr(0, d);
      else if (k < 5) wr(a, d);
      else if (k == 5) fire(4'($urandom));
      else rd(a, "R2 R4 R7 R9 R10 R11 random read");
      @(negedge clk);
      chk("R8 irq random", {7'h0, irq}, {7'h0, exp_irq()});
    end
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule